// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address onto a real address for large, naturally aligned memory blocks, without any page-table walk. It holds two small arrays of block descriptors, one for instruction fetches and one for data loads and stores. Each descriptor is a pair of 32-bit words. The upper word carries the effective base, a block-length mask and two enable bits, one for supervisor mode and one for user mode. The lower word carries the real base and a 2-bit protection code.

A request gives an effective address, the privilege mode and the access kind. The array for that access kind is searched in index order, and the lowest-numbered matching descriptor wins. On a hit the unit forms the real address and decodes the rights from the protection code. It then checks the access against those rights and reports a granted or protection-violation status. If nothing matches, it reports not-found. Software loads the descriptors one word at a time through a simple register write port.

Top module: `bxlat_unit`

## Requirements
- R1: After a synchronous active-low reset, resp_valid is 0 and every descriptor is disabled, so any request returns not-found (status 1) until a descriptor is written.
- R2: A request sampled with req_valid high at a rising edge gives its result at that same edge, with resp_valid high. With req_valid low, resp_valid is low after the edge.
- R3: A descriptor matches when it is enabled for the request's mode and the effective bits [31:17] equal the upper-word base bits [31:17] at every position the mask leaves clear. The enable for supervisor mode (req_user=0) is upper bit 1 and the enable for user mode (req_user=1) is upper bit 0. The block-length mask is upper bits [12:2] and covers effective bits [27:17].
- R4: When several descriptors match, the one with the lowest index is reported on resp_idx.
- R5: On a hit, the real address is formed in three parts. Bits [31:28] are lower-word bits [31:28]. Bits [27:17] are (effective bits [27:17] AND mask) OR lower-word bits [27:17]. Bits [16:0] pass through from the effective address.
- R6: The protection code is lower-word bits [1:0]. Code 0 grants nothing, code 2 grants read, write and execute, and codes 1 and 3 grant read and execute. resp_rights is {read, write, execute}, from bit 2 down to bit 0.
- R7: On a hit, a fetch needs execute, a store needs write and a load needs read. The status is 0 when granted and 2 (protection violation) otherwise. The real address, rights and index are still reported in both cases.
- R8: On a miss the status is 1, and resp_ra, resp_rights and resp_idx are 0.
- R9: A request with req_fetch high searches the instruction array, and any other request searches the data array. req_store has no effect on a fetch. A write with wr_side=1 goes to the instruction array and one with wr_side=0 goes to the data array. A write to one array leaves the other unchanged.
- R10: A write (wr_en high, wr_upper selecting the upper word when 1) changes the descriptor at the rising edge where it is sampled. A request at the next edge already sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Descriptor word write strobe |
| wr_side | input | 1 | 1 = instruction array, 0 = data array |
| wr_idx | input | IDX_W | Descriptor index to write |
| wr_upper | input | 1 | 1 = upper word, 0 = lower word |
| wr_data | input | 32 | Word written |
| req_valid | input | 1 | Translation request strobe |
| req_ea | input | 32 | Effective address |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_fetch | input | 1 | Instruction fetch |
| req_store | input | 1 | Store (when not a fetch), otherwise load |
| resp_valid | output | 1 | Result strobe |
| resp_status | output | 2 | 0 granted, 1 not found, 2 protection violation |
| resp_ra | output | 32 | Real address |
| resp_rights | output | 3 | {read, write, execute} |
| resp_idx | output | IDX_W | Index of the winning descriptor |

## Verification
Each result is registered once, so every response is due at the first rising edge after its request is driven. A descriptor write is likewise due at the edge that samples it. The bench drives every input on a falling edge and compares the response at the next falling edge, half a cycle after the single register has loaded. The write-then-translate sequences therefore test that a freshly written descriptor serves the very next request.

// File: rtl/bxlat_pkg.sv
// Package: shared types and field decoders for the block address translation unit.
// Assumes 32-bit addresses with fixed field positions in the descriptor words.
package bxlat_pkg;

    localparam int ADDR_W = 32;
    localparam int BASE_W = 15;   // effective/real base bits [31:17]
    localparam int MASK_W = 11;   // block-length mask over bits [27:17]

    typedef enum logic [1:0] {
        ST_GRANT = 2'd0,
        ST_MISS  = 2'd1,
        ST_PROT  = 2'd2
    } bx_status_e;

    typedef struct packed {
        logic [BASE_W-1:0] ebase;
        logic [MASK_W-1:0] blk_mask;
        logic              sup_en;
        logic              usr_en;
    } bx_upper_t;

    typedef struct packed {
        logic [BASE_W-1:0] rbase;
        logic [1:0]        prot;
    } bx_lower_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } bx_rights_t;

    // Extract the upper descriptor fields from a written word.
    function automatic bx_upper_t unpack_upper(input logic [ADDR_W-1:0] w);
        bx_upper_t u;
        u.ebase    = w[31:17];
        u.blk_mask = w[12:2];
        u.sup_en   = w[1];
        u.usr_en   = w[0];
        return u;
    endfunction

    // Extract the lower descriptor fields from a written word.
    function automatic bx_lower_t unpack_lower(input logic [ADDR_W-1:0] w);
        bx_lower_t l;
        l.rbase = w[31:17];
        l.prot  = w[1:0];
        return l;
    endfunction

endpackage

// File: rtl/bxlat_bank.sv
// Module: one array of descriptor register pairs with a word write port.
// Assumes that a write to an index outside 0..N-1 is simply dropped.
module bxlat_bank
    import bxlat_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_upper,
    input  logic [ADDR_W-1:0]    wr_data,
    output bx_upper_t            up_o [N],
    output bx_lower_t            lo_o [N]
);

    for (genvar g = 0; g < N; g++) begin : g_ent
        bx_upper_t up_q;
        bx_lower_t lo_q;

        // Hold one descriptor pair: cleared by reset, loaded one word at a time.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                up_q <= '0;
                lo_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                if (wr_upper) begin
                    up_q <= unpack_upper(wr_data);
                end else begin
                    lo_q <= unpack_lower(wr_data);
                end
            end
        end

        assign up_o[g] = up_q;
        assign lo_o[g] = lo_q;
    end

endmodule

// File: rtl/bxlat_search.sv
// Module: match every descriptor against the address, pick the lowest index, form the real address.
// Assumes combinational use; the caller registers the result.
module bxlat_search
    import bxlat_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  bx_upper_t            up_i [N],
    input  bx_lower_t            lo_i [N],
    input  logic [ADDR_W-1:0]    ea,
    input  logic                 user,
    output logic                 hit,
    output logic [IDX_W-1:0]     hit_idx,
    output logic [ADDR_W-1:0]    ra,
    output logic [1:0]           prot
);

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic              en;
        logic [BASE_W-1:0] keep;

        // Mode enable and compare of the address bits outside the block mask.
        always_comb begin
            en       = user ? up_i[g].usr_en : up_i[g].sup_en;
            keep     = {4'hF, ~up_i[g].blk_mask};
            match[g] = en && (((ea[31:17] ^ up_i[g].ebase) & keep) == '0);
        end
    end

    // Priority pick: scanning downward leaves the lowest matching index.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // Merge real base, masked effective bits and the untranslated offset.
    always_comb begin
        ra[31:28] = lo_i[hit_idx].rbase[14:11];
        ra[27:17] = (ea[27:17] & up_i[hit_idx].blk_mask) | lo_i[hit_idx].rbase[10:0];
        ra[16:0]  = ea[16:0];
        prot      = lo_i[hit_idx].prot;
    end

endmodule

// File: rtl/bxlat_rights.sv
// Module: decode the 2-bit protection code and check it against the access kind.
// Assumes a fetch takes precedence over the store flag.
module bxlat_rights
    import bxlat_pkg::*;
(
    input  logic [1:0] prot,
    input  logic       fetch,
    input  logic       store,
    output bx_rights_t rights,
    output logic       allow
);

    // Code 0 blocks all; nonzero reads and executes; code 2 also writes.
    always_comb begin
        rights.rd = (prot != 2'd0);
        rights.ex = (prot != 2'd0);
        rights.wr = (prot == 2'd2);
    end

    // Pick the one right this access kind needs.
    always_comb begin
        if (fetch) begin
            allow = rights.ex;
        end else if (store) begin
            allow = rights.wr;
        end else begin
            allow = rights.rd;
        end
    end

endmodule

// File: rtl/bxlat_unit.sv
// Module: block address translation top: instruction and data descriptor arrays,
// a search by access kind and a single output register stage.
// Assumes one request per cycle; results appear one edge after the request.
module bxlat_unit
    import bxlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_upper,
    input  logic [31:0]       wr_data,
    input  logic              req_valid,
    input  logic [31:0]       req_ea,
    input  logic              req_user,
    input  logic              req_fetch,
    input  logic              req_store,
    output logic              resp_valid,
    output logic [1:0]        resp_status,
    output logic [31:0]       resp_ra,
    output logic [2:0]        resp_rights,
    output logic [IDX_W-1:0]  resp_idx
);

    bx_upper_t        d_up  [NUM_ENTRIES];
    bx_lower_t        d_lo  [NUM_ENTRIES];
    bx_upper_t        i_up  [NUM_ENTRIES];
    bx_lower_t        i_lo  [NUM_ENTRIES];
    bx_upper_t        s_up  [NUM_ENTRIES];
    bx_lower_t        s_lo  [NUM_ENTRIES];
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [31:0]      ra;
    logic [1:0]       prot;
    bx_rights_t       rights;
    logic             allow;

    bxlat_bank #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_dbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && !wr_side),
        .wr_idx   (wr_idx),
        .wr_upper (wr_upper),
        .wr_data  (wr_data),
        .up_o     (d_up),
        .lo_o     (d_lo)
    );

    bxlat_bank #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_ibank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && wr_side),
        .wr_idx   (wr_idx),
        .wr_upper (wr_upper),
        .wr_data  (wr_data),
        .up_o     (i_up),
        .lo_o     (i_lo)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_sel
        // Route the array that belongs to the access kind into the search.
        always_comb begin
            s_up[g] = req_fetch ? i_up[g] : d_up[g];
            s_lo[g] = req_fetch ? i_lo[g] : d_lo[g];
        end
    end

    bxlat_search #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_search (
        .up_i    (s_up),
        .lo_i    (s_lo),
        .ea      (req_ea),
        .user    (req_user),
        .hit     (hit),
        .hit_idx (hit_idx),
        .ra      (ra),
        .prot    (prot)
    );

    bxlat_rights u_rights (
        .prot   (prot),
        .fetch  (req_fetch),
        .store  (req_store),
        .rights (rights),
        .allow  (allow)
    );

    // Register the verdict; a miss reports zeros for address, rights and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_status <= ST_GRANT;
            resp_ra     <= '0;
            resp_rights <= '0;
            resp_idx    <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                if (!hit) begin
                    resp_status <= ST_MISS;
                    resp_ra     <= '0;
                    resp_rights <= '0;
                    resp_idx    <= '0;
                end else begin
                    resp_status <= allow ? ST_GRANT : ST_PROT;
                    resp_ra     <= ra;
                    resp_rights <= rights;
                    resp_idx    <= hit_idx;
                end
            end
        end
    end

endmodule

// File: rtl/bxlat_unit_chk.sv
// Module: temporal checks on the translation unit's ports, attached by bind.
// Assumes the synchronous active-low reset of the unit.
module bxlat_unit_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [31:0]      req_ea,
    input logic             req_fetch,
    input logic             req_store,
    input logic             resp_valid,
    input logic [1:0]       resp_status,
    input logic [31:0]      resp_ra,
    input logic [2:0]       resp_rights,
    input logic [IDX_W-1:0] resp_idx
);

    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    p_miss_zeroed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == 2'd1) |-> (resp_ra == '0 && resp_rights == '0 && resp_idx == '0));

    p_rights_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_rights == 3'b000 || resp_rights == 3'b101 || resp_rights == 3'b111));

    p_grant_has_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == 2'd0) |->
            ($past(req_fetch) ? resp_rights[0] : ($past(req_store) ? resp_rights[1] : resp_rights[2])));

    p_offset_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status != 2'd1) |-> (resp_ra[16:0] == $past(req_ea[16:0])));

    p_status_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_status != 2'd3));

endmodule

bind bxlat_unit bxlat_unit_chk #(.IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ea      (req_ea),
    .req_fetch   (req_fetch),
    .req_store   (req_store),
    .resp_valid  (resp_valid),
    .resp_status (resp_status),
    .resp_ra     (resp_ra),
    .resp_rights (resp_rights),
    .resp_idx    (resp_idx)
);

// File: tb/bxlat_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random traffic against a descriptor model.
module bxlat_unit_tb_top;

    localparam int N     = 4;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_side = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic             wr_upper = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             req_valid = 1'b0;
    logic [31:0]      req_ea = '0;
    logic             req_user = 1'b0;
    logic             req_fetch = 1'b0;
    logic             req_store = 1'b0;
    logic             resp_valid;
    logic [1:0]       resp_status;
    logic [31:0]      resp_ra;
    logic [2:0]       resp_rights;
    logic [IDX_W-1:0] resp_idx;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_up [2][N];
    logic [31:0] m_lo [2][N];

    always #4 clk = ~clk;

    bxlat_unit #(.NUM_ENTRIES(N), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx),
        .wr_upper(wr_upper), .wr_data(wr_data), .req_valid(req_valid), .req_ea(req_ea),
        .req_user(req_user), .req_fetch(req_fetch), .req_store(req_store),
        .resp_valid(resp_valid), .resp_status(resp_status), .resp_ra(resp_ra),
        .resp_rights(resp_rights), .resp_idx(resp_idx)
    );

    // Expected result from the requirements text.
    function automatic void predict(input logic [31:0] ea, input logic user, input logic fetch,
                                    input logic store, output logic [1:0] st,
                                    output logic [31:0] ra, output logic [2:0] rt,
                                    output logic [1:0] ix);
        int side = fetch ? 1 : 0;
        st = 2'd1; ra = '0; rt = '0; ix = '0;
        for (int i = 0; i < N; i++) begin
            logic [31:0] u = m_up[side][i];
            logic [31:0] l = m_lo[side][i];
            logic [10:0] mk = u[12:2];
            logic        en = user ? u[0] : u[1];
            logic        need;
            if (en && (((ea[31:17] ^ u[31:17]) & {4'hF, ~mk}) == 15'd0)) begin
                ra = {l[31:28], (ea[27:17] & mk) | l[27:17], ea[16:0]};
                rt = (l[1:0] == 2'd0) ? 3'b000 : ((l[1:0] == 2'd2) ? 3'b111 : 3'b101);
                need = fetch ? rt[0] : (store ? rt[1] : rt[2]);
                st = need ? 2'd0 : 2'd2;
                ix = 2'(i);
                return;
            end
        end
    endfunction

    task automatic do_write(input logic side, input int idx, input logic upper, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_side = side; wr_idx = IDX_W'(idx); wr_upper = upper; wr_data = d;
        if (upper) m_up[side][idx] = d; else m_lo[side][idx] = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] ea, input logic user, input logic fetch,
                          input logic store, input string tag);
        logic [1:0] es; logic [31:0] er; logic [2:0] et; logic [1:0] ei;
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_user = user; req_fetch = fetch; req_store = store;
        predict(ea, user, fetch, store, es, er, et, ei);
        @(negedge clk);
        checks++;
        if (resp_valid !== 1'b1 || resp_status !== es || resp_ra !== er ||
            resp_rights !== et || resp_idx !== ei) begin
            fails++;
            $display("FAIL %s: got v=%0b st=%0d ra=%h rt=%b ix=%0d exp v=1 st=%0d ra=%h rt=%b ix=%0d",
                     tag, resp_valid, resp_status, resp_ra, resp_rights, resp_idx, es, er, et, ei);
        end
        req_valid = 1'b0;
    endtask

    // Upper word: base[31:17], mask[12:2], sup_en bit1, usr_en bit0.
    function automatic logic [31:0] mk_up(input logic [14:0] b, input logic [10:0] m,
                                          input logic s, input logic u);
        return {b, 4'h0, m, s, u};
    endfunction

    function automatic logic [31:0] mk_lo(input logic [14:0] b, input logic [1:0] p);
        return {b, 15'h0, p};
    endfunction

    initial begin
        repeat (10000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < N; i++) begin m_up[s][i] = '0; m_lo[s][i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle output and empty arrays after reset.
        @(negedge clk);
        checks++;
        if (resp_valid !== 1'b0) begin
            fails++; $display("FAIL R1: got resp_valid=%0b exp 0", resp_valid);
        end
        do_req(32'h1234_5678, 1'b0, 1'b0, 1'b0, "R1 data miss after reset");
        do_req(32'h1234_5678, 1'b1, 1'b1, 1'b0, "R1 fetch miss after reset");

        // R10 and R5: write data entry 1 then translate in the next cycle.
        do_write(1'b0, 1, 1'b0, mk_lo(15'h4003, 2'd2));
        do_write(1'b0, 1, 1'b1, mk_up(15'h0100, 11'h00F, 1'b1, 1'b0));
        do_req(32'h0205_ABCD, 1'b0, 1'b0, 1'b1, "R10 R5 store right after write");
        // R3: same address in user mode misses (user enable clear).
        do_req(32'h0205_ABCD, 1'b1, 1'b0, 1'b0, "R3 user enable clear");
        // R3: bit outside mask differs -> miss.
        do_req(32'h0225_0000, 1'b0, 1'b0, 1'b0, "R3 unmasked bit differs");
        // R9: fetch uses instruction array (empty) -> miss; store flag ignored.
        do_req(32'h0205_ABCD, 1'b0, 1'b1, 1'b1, "R9 fetch looks at instruction array");

        // R4: entry 0 overlapping entry 1 wins.
        do_write(1'b0, 0, 1'b0, mk_lo(15'h7FF0, 2'd1));
        do_write(1'b0, 0, 1'b1, mk_up(15'h0100, 11'h0FF, 1'b1, 1'b1));
        do_req(32'h0207_0010, 1'b0, 1'b0, 1'b0, "R4 lowest index wins");
        // R7: store to read-only code -> violation.
        do_req(32'h0207_0010, 1'b1, 1'b0, 1'b1, "R7 store on code 1");

        // R6 R7: instruction array codes 0,3,2 on entries 2,3,0.
        do_write(1'b1, 2, 1'b1, mk_up(15'h2000, 11'h000, 1'b1, 1'b1));
        do_write(1'b1, 2, 1'b0, mk_lo(15'h1000, 2'd0));
        do_req(32'h4000_0100, 1'b0, 1'b1, 1'b0, "R6 code 0 fetch denied");
        do_write(1'b1, 3, 1'b1, mk_up(15'h3000, 11'h7FF, 1'b0, 1'b1));
        do_write(1'b1, 3, 1'b0, mk_lo(15'h0555, 2'd3));
        do_req(32'h6ABC_DEF0, 1'b1, 1'b1, 1'b0, "R6 code 3 fetch granted full mask");
        do_req(32'h6ABC_DEF0, 1'b0, 1'b1, 1'b0, "R3 supervisor enable clear");
        do_write(1'b1, 0, 1'b1, mk_up(15'h3000, 11'h7FF, 1'b1, 1'b1));
        do_write(1'b1, 0, 1'b0, mk_lo(15'h7800, 2'd2));
        do_req(32'h6ABC_DEF0, 1'b1, 1'b1, 1'b0, "R4 R6 code 2 entry 0 preferred");
        // R9: data array untouched by instruction writes.
        do_req(32'h6ABC_DEF0, 1'b1, 1'b0, 1'b0, "R9 data array unaffected");
        // R8: miss on data array.
        do_req(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R8 miss zeros");

        // Random traffic: R3 R4 R5 R6 R7 R8 R9 R10.
        for (int it = 0; it < 600; it++) begin
            int r = $urandom_range(0, 99);
            if (r < 30) begin
                logic s = 1'($urandom_range(0, 1));
                int   i = $urandom_range(0, N - 1);
                logic [31:0] w = $urandom;
                if (r < 15) do_write(s, i, 1'b1, w & 32'hFFFE_1FFF);
                else        do_write(s, i, 1'b0, w);
            end else begin
                logic        f  = 1'($urandom_range(0, 1));
                logic [31:0] u  = m_up[f ? 1 : 0][$urandom_range(0, N - 1)];
                logic [31:0] rn = $urandom;
                logic [31:0] ea;
                if (r < 80) ea = {u[31:17] ^ (rn[31:17] & {4'h0, u[12:2]}), rn[16:0]};
                else        ea = rn;
                do_req(ea, 1'($urandom_range(0, 1)), f, 1'($urandom_range(0, 1)), "R3-random");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule